// File: doc/BRIEF.md
# Periodic Comparator Timer Channel

This block is one channel of an event timer. It watches a free-running main counter that is produced elsewhere and compares it against a programmable comparator. When the two agree, it raises a one-cycle interrupt status pulse. In one-shot mode, a match fires once and then stays quiet until software rewrites the comparator. In periodic mode, each match moves the comparator forward by a stored period, so the channel keeps firing at a fixed interval.

Software reaches the channel through a small register port. Address 0 holds the configuration word, address 1 the low half of the comparator and address 2 the high half. Address 3 is read-only and shows the counter high half as the channel sees it. A parameter selects one of two builds. The full build has a 64-bit comparator, supports periodic mode and can be narrowed to 32 bits at run time. The reduced build is a 32-bit, one-shot-only channel. Bus decoding, the counter itself and delivery of the interrupt are outside the block.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the comparator and the stored period are zero, periodic mode and 32-bit mode are off, no write is armed and `irq_pulse` is low.
- R2: The configuration word (address 0) has this layout: bit 0 selects periodic mode (1) or one-shot mode (0); bit 1 selects 32-bit mode; bit 2 is the value-set request; bit 4 is the size capability; bit 5 is the periodic capability. Bits 4 and 5 read 1 on the full build. Bit 2, bit 3 (reserved) and bits 31:6 always read 0.
- R3: On the reduced build (parameter FULL=0), the periodic and 32-bit bits are hardwired to 0 and writes to them are ignored. The capability bits read 0. The comparator high half (address 2) reads 0 and writes to it are ignored.
- R4: In one-shot mode, a cycle in which the counter equals the comparator while the channel is enabled makes `irq_pulse` high for exactly the following cycle. Further matches produce no pulse until one of the comparator halves is written.
- R5: In periodic mode, each match produces one pulse, and on the same clock edge the comparator advances by the stored period.
- R6: A write to a comparator half always stores the data into the matching half of the period. In one-shot mode it also loads the comparator half. In periodic mode without an armed value-set, the comparator is left unchanged.
- R7: Writing the configuration word with bit 2 set and bit 0 set arms the channel. The next comparator-half write then loads both that comparator half and that period half, and the arm clears after that one write. Bit 2 is ignored when bit 0 is written as 0.
- R8: In 32-bit mode (full build), match compares only the low 32 bits. The periodic advance wraps within the low 32 bits and leaves the high comparator half unchanged. Address 3 reads 0. With 32-bit mode off, address 3 reads bits 63:32 of the counter.
- R9: While `chan_en` is low, no pulse is produced, and a match changes neither the comparator nor the one-shot state.
- R10: A comparator write and a match can fall in the same cycle. The pulse is then still produced from the comparator value held before the write. In each written half the written value takes priority over the periodic advance, and a periodic advance that does occur uses the period held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; matches are acted on only while high |
| cnt_val | input | 64 | Current main counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 config, 1 comparator low, 2 comparator high |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read address: 0 config, 1 comparator low, 2 comparator high, 3 counter high view |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| irq_pulse | output | 1 | One-cycle interrupt status pulse |

## Verification
The case that needs care is a comparator write landing in the same cycle as a match. This happens in two places.

In one-shot mode, the comparator is rewritten while the counter is still parked on the value that already fired. No pulse may appear in the write cycle. Exactly one pulse must follow one cycle later, because the write re-arms the channel.

In periodic mode, a period-only write arrives on the matching cycle. The bench expects the pulse, then reads back the comparator. The comparator must have advanced by the old period, and the next match must use the new period. The expected pulse cycles go into a queue, and any pulse that is missing, early or extra is counted as a failure.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int HALF_W = 32;
    localparam int CNT_W  = 2 * HALF_W;

    // configuration word bit positions
    localparam int B_PERIODIC = 0;
    localparam int B_NARROW   = 1;
    localparam int B_VSET     = 2;
    localparam int B_SIZE_CAP = 4;
    localparam int B_PER_CAP  = 5;

    typedef struct packed {
        logic periodic;
        logic mode32;
        logic armed;
    } cfg_t;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
    import tmr_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cmp_we,
    input  logic [2:0] wr_bits,
    output cfg_t       cfg
);
    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmp_we) begin
            st_d.armed = 1'b0;
        end
        if (cfg_we) begin
            st_d.periodic = FULL ? wr_bits[B_PERIODIC] : 1'b0;
            st_d.mode32   = FULL ? wr_bits[B_NARROW]   : 1'b0;
            st_d.armed    = wr_bits[B_VSET] && st_d.periodic;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q;

    p_armed_needs_periodic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> st_q.periodic);

    p_cmp_write_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && !cfg_we) |=> !st_q.armed);
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    input  cfg_t              cfg,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] per;
        logic             fired;
        logic             irq;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    logic             narrow;
    logic             lo_eq, hi_eq, match, hit, load_cmp, hi_ok;
    logic [CNT_W-1:0] sum;

    always_comb begin
        narrow   = cfg.mode32 || !FULL;
        lo_eq    = cnt_val[HALF_W-1:0] == st_q.cmp[HALF_W-1:0];
        hi_eq    = cnt_val[CNT_W-1:HALF_W] == st_q.cmp[CNT_W-1:HALF_W];
        match    = lo_eq && (narrow || hi_eq);
        hit      = chan_en && match && (cfg.periodic || !st_q.fired);
        load_cmp = !cfg.periodic || cfg.armed;
        hi_ok    = wr_hi && FULL;
        sum      = st_q.cmp + st_q.per;

        st_d     = st_q;
        st_d.irq = hit;

        if (hit) begin
            if (cfg.periodic) begin
                st_d.cmp = narrow ? {st_q.cmp[CNT_W-1:HALF_W], sum[HALF_W-1:0]} : sum;
            end else begin
                st_d.fired = 1'b1;
            end
        end

        if (wr_lo) begin
            st_d.per[HALF_W-1:0] = wr_data;
            if (load_cmp) begin
                st_d.cmp[HALF_W-1:0] = wr_data;
            end
            st_d.fired = 1'b0;
        end

        if (hi_ok) begin
            st_d.per[CNT_W-1:HALF_W] = wr_data;
            if (load_cmp) begin
                st_d.cmp[CNT_W-1:HALF_W] = wr_data;
            end
            st_d.fired = 1'b0;
        end

        if (!FULL) begin
            st_d.cmp[CNT_W-1:HALF_W] = '0;
            st_d.per[CNT_W-1:HALF_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_val = st_q.cmp;
    assign irq     = st_q.irq;

    p_pulse_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(chan_en));

    p_oneshot_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fired && !cfg.periodic && !wr_lo && !wr_hi) |=> !st_q.irq);

    p_period_moves_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && $past(cfg.periodic && !wr_lo && !wr_hi && (st_q.per[HALF_W-1:0] != '0)))
        |-> (st_q.cmp[HALF_W-1:0] != $past(st_q.cmp[HALF_W-1:0])));

    p_narrow_keeps_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode32 && !wr_hi) |=> $stable(st_q.cmp[CNT_W-1:HALF_W]));
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic [1:0]        rd_sel,
    input  logic              periodic,
    input  logic              mode32,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic [HALF_W-1:0] cnt_hi,
    output logic [HALF_W-1:0] rd_data
);
    logic [HALF_W-1:0] cfg_word;

    always_comb begin
        cfg_word             = '0;
        cfg_word[B_PERIODIC] = periodic;
        cfg_word[B_NARROW]   = mode32;
        cfg_word[B_SIZE_CAP] = FULL;
        cfg_word[B_PER_CAP]  = FULL;
        unique case (rd_sel)
            2'd0:    rd_data = cfg_word;
            2'd1:    rd_data = cmp_val[HALF_W-1:0];
            2'd2:    rd_data = cmp_val[CNT_W-1:HALF_W];
            default: rd_data = (mode32 || !FULL) ? '0 : cnt_hi;
        endcase
    end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import tmr_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chan_en,
    input  logic [63:0] cnt_val,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        irq_pulse
);
    logic             wr_cfg, wr_lo, wr_hi;
    cfg_t             cfg;
    logic [CNT_W-1:0] cmp_val;

    assign wr_cfg = wr_en && (wr_sel == 2'd0);
    assign wr_lo  = wr_en && (wr_sel == 2'd1);
    assign wr_hi  = wr_en && (wr_sel == 2'd2);

    tmr_cfg_reg #(.FULL(FULL)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (wr_cfg),
        .cmp_we  (wr_lo || wr_hi),
        .wr_bits (wr_data[2:0]),
        .cfg     (cfg)
    );

    tmr_cmp_unit #(.FULL(FULL)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .cnt_val (cnt_val),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .cfg     (cfg),
        .cmp_val (cmp_val),
        .irq     (irq_pulse)
    );

    tmr_rd_mux #(.FULL(FULL)) u_rd (
        .rd_sel   (rd_sel),
        .periodic (cfg.periodic),
        .mode32   (cfg.mode32),
        .cmp_val  (cmp_val),
        .cnt_hi   (cnt_val[CNT_W-1:HALF_W]),
        .rd_data  (rd_data)
    );

    generate
        if (!FULL) begin : g_reduced
            p_reduced_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_sel == 2'd2) |-> (rd_data == '0));
        end
    endgenerate
endmodule

// File: tb/cmp_timer_chan_bench.sv
module cmp_timer_chan_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] cnt_val = 64'd5;
    logic [1:0]  wr_sel = 2'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_f, rd_r;
    logic        irq_f, irq_r;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmp_timer_chan #(.FULL(1'b1)) u_cmp_timer_chan (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cnt_val(cnt_val),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_f), .irq_pulse(irq_f)
    );

    cmp_timer_chan #(.FULL(1'b0)) u_red (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cnt_val(cnt_val),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_r), .irq_pulse(irq_r)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [63:0] c, input logic we,
                         input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cnt_val = c;
        wr_en   = we;
        wr_sel  = sel;
        wr_data = d;
    endtask

    task automatic hold(input logic [63:0] c);
        drive(c, 1'b0, 2'd0, 32'd0);
    endtask

    task automatic expect_pulse();
        exp_q.push_back(cyc + 1);
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        wr_en  = 1'b0;
        rd_sel = sel;
        #1;
        chk(rd_f == exp, req, "full readback", rd_f, exp);
    endtask

    task automatic rdr(input logic [1:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        wr_en  = 1'b0;
        rd_sel = sel;
        #1;
        chk(rd_r == exp, req, "reduced readback", rd_r, exp);
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // monitor: pops expected pulse cycles and compares against the design
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                chk(1'b0, "R4/R5", "missed pulse at cycle", cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (irq_f) begin
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    chk(1'b1, "R4/R5", "pulse", cyc, cyc);
                    void'(exp_q.pop_front());
                end else begin
                    chk(1'b0, "R4/R9", "unexpected pulse at cycle", cyc, 0);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R1", "watchdog expired", cyc, 0);
            report();
            $finish;
        end
    end

    initial begin
        logic [63:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2, R3: reset state and capability bits
        rd(2'd0, 32'h30, "R1");
        rd(2'd1, 32'h0, "R1");
        chk(irq_f == 1'b0, "R1", "irq after reset", irq_f, 0);
        rdr(2'd0, 32'h0, "R3");

        // R4, R6: one-shot
        drive(64'd5, 1'b1, 2'd1, 32'd100);
        drive(64'd5, 1'b1, 2'd2, 32'd0);
        chan_en = 1'b1;
        hold(64'd98);
        hold(64'd99);
        hold(64'd100); expect_pulse();
        hold(64'd100);
        chk(irq_r == 1'b1, "R4", "reduced one-shot pulse", irq_r, 1);
        hold(64'd101);
        chk(irq_r == 1'b0, "R4", "reduced second pulse", irq_r, 0);

        // R10 / R4: rewrite in the cycle the fired value is still present
        hold(64'd100);
        drive(64'd100, 1'b1, 2'd1, 32'd100);
        hold(64'd100); expect_pulse();
        hold(64'd101);

        // R9: enable low blocks the pulse and keeps the one-shot armed
        drive(64'd101, 1'b1, 2'd1, 32'd200);
        chan_en = 1'b0;
        hold(64'd200);
        hold(64'd200);
        chan_en = 1'b1; expect_pulse();
        hold(64'd201);

        // R2, R3: periodic select
        drive(64'd201, 1'b1, 2'd0, 32'h1);
        rd(2'd0, 32'h31, "R2");
        rdr(2'd0, 32'h0, "R3");

        // R6, R5: period-only write, then advance
        drive(64'd201, 1'b1, 2'd1, 32'd50);
        rd(2'd1, 32'd200, "R6");
        hold(64'd200); expect_pulse();
        rd(2'd1, 32'd250, "R5");
        hold(64'd250); expect_pulse();
        rd(2'd1, 32'd300, "R5");

        // R7: value-set
        drive(64'd250, 1'b1, 2'd0, 32'h5);
        rd(2'd0, 32'h31, "R7");
        drive(64'd250, 1'b1, 2'd1, 32'd1000);
        rd(2'd1, 32'd1000, "R7");
        drive(64'd250, 1'b1, 2'd1, 32'd10);
        rd(2'd1, 32'd1000, "R7");

        // R10: period write in the matching cycle
        drive(64'd1000, 1'b1, 2'd1, 32'd20); expect_pulse();
        rd(2'd1, 32'd1010, "R10");
        hold(64'd1010); expect_pulse();
        rd(2'd1, 32'd1030, "R10");

        // R8: 32-bit mode
        drive(64'd1010, 1'b1, 2'd0, 32'h3);
        drive(64'd1010, 1'b1, 2'd0, 32'h7);
        drive(64'd1010, 1'b1, 2'd2, 32'd5);
        rd(2'd2, 32'd5, "R7");
        rdr(2'd2, 32'd0, "R3");
        c = {32'd7, 32'd1030};
        hold(c); expect_pulse();
        rd(2'd1, 32'd1050, "R8");
        rd(2'd3, 32'd0, "R8");
        drive(c, 1'b1, 2'd0, 32'h7);
        drive(c, 1'b1, 2'd1, 32'hFFFF_FFF0);
        drive(c, 1'b1, 2'd1, 32'h20);
        hold({32'd7, 32'hFFFF_FFF0}); expect_pulse();
        rd(2'd1, 32'h10, "R8");
        rd(2'd2, 32'd5, "R8");

        // R8 contrast: 64-bit match needs the high half
        drive({32'd7, 32'hFFFF_FFF0}, 1'b1, 2'd0, 32'h1);
        hold({32'd0, 32'h10});
        c = {32'd5, 32'h10};
        hold(c); expect_pulse();
        rd(2'd3, 32'd5, "R8");
        rd(2'd2, 32'd10, "R5");
        rd(2'd1, 32'h30, "R5");

        // R7: value-set ignored in one-shot mode
        drive(c, 1'b1, 2'd0, 32'h0);
        drive(c, 1'b1, 2'd1, 32'h40);
        drive(c, 1'b1, 2'd0, 32'h4);
        rd(2'd0, 32'h30, "R7");
        drive(c, 1'b1, 2'd0, 32'h1);
        drive(c, 1'b1, 2'd1, 32'h99);
        rd(2'd1, 32'h40, "R7");

        hold(c);
        hold(c);
        hold(c);
        chk(exp_q.size() == 0, "R5", "pending expected pulses", exp_q.size(), 0);
        done = 1'b1;
        report();
        $finish;
    end
endmodule